// File: doc/BRIEF.md
# Triggered One-Shot Motor Throttle Pulse Generator

This block drives one throttle pulse per channel to a set of motor speed controllers each time a host strobes its trigger. All channels share one tick prescaler and one frame counter. Each channel has its own compare value. A frame lasts `FRAME_TICKS` ticks, which is 4016 by default. At 16 ticks per microsecond that is 251 µs.

Inside a frame, each output is held low during a lead-in and then driven high until the frame ends. The pulse therefore always finishes exactly on the frame boundary. The high time in ticks equals the throttle value, clamped to the range 2000 to 4000 (125 µs to 250 µs). The lead-in is the frame length minus that value, so it is never shorter than 16 ticks. After a frame the counter halts until the next trigger. A trigger that arrives mid-frame is remembered together with its throttle values, and it starts the next frame the moment the current one ends.

A host writes fresh throttle values and pulses `trig` once per control loop. The system clock is divided by `TICK_DIV` to form the counting tick.

Top module: `oneshot_esc`

## Requirements
- R1: After reset, `busy` is 0 and every bit of `pulseOut` is 0. Both stay at 0 while no frame runs.
- R2: While idle, a trigger seen at a rising clock edge starts a frame. `busy` reads 1 from the following cycle and stays 1 for exactly `FRAME_TICKS*TICK_DIV` cycles.
- R3: Within a frame, channel i is low for the first `(FRAME_TICKS - T)*TICK_DIV` cycles and high for the remaining `T*TICK_DIV` cycles. T is the channel's clamped throttle. The high phase never ends before the frame boundary.
- R4: Every frame opens with channel outputs low for at least `(FRAME_TICKS - THR_MAX)` ticks (32 cycles in the bench), even at full throttle.
- R5: A throttle below `THR_MIN` (2000) acts as 2000, and one above `THR_MAX` (4000) acts as 4000.
- R6: A trigger during a running frame does not alter that frame. The next frame starts with no gap in the cycle after the current frame's last cycle. It uses the throttle values presented with the latest such trigger.
- R7: A trigger in the last cycle of a frame starts the next frame at once, using the throttle values presented with that trigger.
- R8: When a frame ends with no trigger pending, `busy` and all outputs fall to 0 and stay there until the next trigger.
- R9: Channel i takes its throttle from bits `[i*THR_W +: THR_W]` of `thrIn`. Channels with different throttles produce independent widths on the same frame timing.
- R10: A change of `thrIn` without a trigger has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Single-cycle frame request strobe |
| thrIn | input | NCH*THR_W | Packed throttle values, channel i at `[i*THR_W +: THR_W]`, in ticks |
| pulseOut | output | NCH | Per-channel output pins |
| busy | output | 1 | High while a frame is running |

## Verification
The bench aims at the frame boundary. It places one trigger in the exact last cycle of a frame. A design that treated that trigger as mid-frame would insert a stray idle cycle, and one that ignored it would drop the frame. Further triggers land mid-frame to show that a pulse is never cut short and that the newest pending values win. A stale-shadow bug would replay the older values. Out-of-range throttles at both ends expose a missing clamp: the lead-in would vanish or the pulse would shrink. Throttle changes with no trigger catch a design that reads its inputs directly.

// File: rtl/oneshot_esc_pkg.sv
package oneshot_esc_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic start;      // reload counter and prescaler, load active compares
    logic fromShadow; // load active compares from shadow instead of inputs
    logic capture;    // store input compares into the shadow registers
    logic run;        // frame in progress
  } ctrlStrobe_t;
endpackage

// File: rtl/oneshot_esc_cmp.sv
module oneshot_esc_cmp #(
  parameter int THR_W       = 12,
  parameter int CNT_W       = 12,
  parameter int FRAME_TICKS = 4016,
  parameter int THR_MIN     = 2000,
  parameter int THR_MAX     = 4000
) (
  input  logic [THR_W-1:0] thr,
  output logic [CNT_W-1:0] cmpVal
);
  localparam logic [THR_W-1:0] MIN_V = THR_W'(THR_MIN);
  localparam logic [THR_W-1:0] MAX_V = THR_W'(THR_MAX);

  logic [THR_W-1:0] thrClamped;

  always_comb begin
    if (thr < MIN_V)      thrClamped = MIN_V;
    else if (thr > MAX_V) thrClamped = MAX_V;
    else                  thrClamped = thr;
    // Compare point is where the low lead-in hands over to the high phase
    cmpVal = CNT_W'(32'(FRAME_TICKS) - 32'(thrClamped));
  end
endmodule

// File: rtl/oneshot_esc_ctrl.sv
module oneshot_esc_ctrl
  import oneshot_esc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trig,
  input  logic        frameEnd,
  output ctrlStrobe_t strb,
  output logic        pending,
  output logic        busy
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t stateQ, stateD;
  logic   pendQ, pendD;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    pendD  = pendQ;
    unique case (stateQ)
      S_IDLE: begin
        if (trig) begin
          strb.start = 1'b1;
          stateD     = S_RUN;
        end
      end
      S_RUN: begin
        strb.run = 1'b1;
        if (frameEnd) begin
          pendD = 1'b0;
          if (trig) begin
            strb.start = 1'b1;          // same-edge trigger wins over pending
          end else if (pendQ) begin
            strb.start      = 1'b1;
            strb.fromShadow = 1'b1;
          end else begin
            stateD = S_IDLE;
          end
        end else if (trig) begin
          strb.capture = 1'b1;
          pendD        = 1'b1;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
    end
  end

  assign pending = pendQ;
  assign busy    = (stateQ == S_RUN);
endmodule

// File: rtl/oneshot_esc_dpath.sv
module oneshot_esc_dpath
  import oneshot_esc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int THR_W       = 12,
  parameter int TICK_DIV    = 5,
  parameter int FRAME_TICKS = 4016,
  parameter int THR_MIN     = 2000,
  parameter int THR_MAX     = 4000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [NCH*THR_W-1:0] thrIn,
  output logic               frameEnd,
  output logic [NCH-1:0]     pulseOut
);
  localparam int CNT_W = $clog2(FRAME_TICKS);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_TICKS - 1);

  logic             tick;
  logic [CNT_W-1:0] cntQ;

  // Tick prescaler: variant chosen by the divide ratio
  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] preQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          preQ <= '0;
        else if (strb.start) preQ <= '0;
        else if (strb.run)  preQ <= (preQ == PRE_LAST) ? '0 : preQ + 1'b1;
      end
      assign tick = (preQ == PRE_LAST);
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign frameEnd = strb.run && tick && (cntQ == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cntQ <= '0;
    else if (strb.start)        cntQ <= '0;
    else if (frameEnd)          cntQ <= '0;
    else if (strb.run && tick)  cntQ <= cntQ + 1'b1;
  end

  // Per-channel compare path
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [CNT_W-1:0] newCmp, shadowQ, activeQ;

      oneshot_esc_cmp #(
        .THR_W(THR_W), .CNT_W(CNT_W), .FRAME_TICKS(FRAME_TICKS),
        .THR_MIN(THR_MIN), .THR_MAX(THR_MAX)
      ) u_cmp (
        .thr   (thrIn[i*THR_W +: THR_W]),
        .cmpVal(newCmp)
      );

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shadowQ <= CNT_W'(FRAME_TICKS - THR_MIN);
          activeQ <= CNT_W'(FRAME_TICKS - THR_MIN);
        end else begin
          if (strb.capture) shadowQ <= newCmp;
          if (strb.start)   activeQ <= strb.fromShadow ? shadowQ : newCmp;
        end
      end

      assign pulseOut[i] = strb.run && (cntQ >= activeQ);
    end
  endgenerate
endmodule

// File: rtl/oneshot_esc.sv
module oneshot_esc
  import oneshot_esc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int THR_W       = 12,
  parameter int TICK_DIV    = 5,
  parameter int FRAME_TICKS = 4016,
  parameter int THR_MIN     = 2000,
  parameter int THR_MAX     = 4000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trig,
  input  logic [NCH*THR_W-1:0] thrIn,
  output logic [NCH-1:0]       pulseOut,
  output logic                 busy
);
  ctrlStrobe_t strb;
  logic        frameEnd;
  logic        pending;

  oneshot_esc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trig(trig), .frameEnd(frameEnd),
    .strb(strb), .pending(pending), .busy(busy)
  );

  oneshot_esc_dpath #(
    .NCH(NCH), .THR_W(THR_W), .TICK_DIV(TICK_DIV), .FRAME_TICKS(FRAME_TICKS),
    .THR_MIN(THR_MIN), .THR_MAX(THR_MAX)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .thrIn(thrIn),
    .frameEnd(frameEnd), .pulseOut(pulseOut)
  );
endmodule

// File: rtl/oneshot_esc_chk.sv
module oneshot_esc_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           trig,
  input logic           busy,
  input logic           frameEnd,
  input logic           pending,
  input logic [NCH-1:0] pulseOut
);
  // R1: outputs quiet whenever no frame runs
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (pulseOut == '0));

  // R2: an idle trigger starts a frame on the next cycle
  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (trig && !busy) |=> busy);

  // R4: every frame opens with all outputs low
  a_r4_lead_open: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (pulseOut == '0));

  a_r4_lead_restart: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (pulseOut == '0));

  // R6: a pending request restarts without a gap
  a_r6_pending_restart: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && pending) |=> busy);

  // R8: nothing pending means the block goes idle
  a_r8_stop: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !pending && !trig) |=> !busy);

  // R3: a high phase only ends at the frame boundary
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      a_r3_no_trunc: assert property (@(posedge clk) disable iff (!rstN)
        (pulseOut[i] && !frameEnd) |=> pulseOut[i]);
    end
  endgenerate
endmodule

bind oneshot_esc oneshot_esc_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .trig(trig), .busy(busy),
  .frameEnd(frameEnd), .pending(pending), .pulseOut(pulseOut)
);

// File: tb/sim_oneshot_esc.sv
module sim_oneshot_esc;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 2;
  localparam int THR_W = 12;
  localparam int DIV   = 2;
  localparam int FRAME = 4016;
  localparam int MINT  = 2000;
  localparam int MAXT  = 4000;
  localparam int FL    = FRAME * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 1'b0;
  logic [NCH*THR_W-1:0] thrIn = '0;
  wire  [NCH-1:0] pulseOut;
  wire  busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_esc #(
    .NCH(NCH), .THR_W(THR_W), .TICK_DIV(DIV), .FRAME_TICKS(FRAME),
    .THR_MIN(MINT), .THR_MAX(MAXT)
  ) u0 (
    .clk(clk), .rstN(rstN), .trig(trig), .thrIn(thrIn),
    .pulseOut(pulseOut), .busy(busy)
  );

  int    nChecks = 0;
  int    nFail   = 0;
  string curReq  = "R1";

  // Behavioural reference: position in cycles inside the frame
  int refRun = 0, refPos = 0, refPend = 0;
  int refThr[NCH];
  int pendThr[NCH];

  function automatic int clampThr(int v);
    if (v < MINT) return MINT;
    if (v > MAXT) return MAXT;
    return v;
  endfunction

  function automatic int inThr(int ch);
    return int'(thrIn[ch*THR_W +: THR_W]);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      refRun = 0; refPos = 0; refPend = 0;
    end else if (refRun != 0) begin
      if (refPos == FL - 1) begin
        refPos = 0;
        if (trig) begin
          for (int c = 0; c < NCH; c++) refThr[c] = clampThr(inThr(c));
        end else if (refPend != 0) begin
          for (int c = 0; c < NCH; c++) refThr[c] = pendThr[c];
        end else begin
          refRun = 0;
        end
        refPend = 0;
      end else begin
        refPos++;
        if (trig) begin
          refPend = 1;
          for (int c = 0; c < NCH; c++) pendThr[c] = clampThr(inThr(c));
        end
      end
    end else if (trig) begin
      refRun = 1; refPos = 0;
      for (int c = 0; c < NCH; c++) refThr[c] = clampThr(inThr(c));
    end
  end

  always @(negedge clk) begin
    int expP;
    check(curReq, int'(busy), refRun, "busy");
    for (int c = 0; c < NCH; c++) begin
      expP = (refRun != 0 && refPos >= (FRAME - refThr[c]) * DIV) ? 1 : 0;
      check(curReq, int'(pulseOut[c]), expP, $sformatf("pulseOut[%0d]", c));
    end
  end

  task automatic setThr(int t0, int t1);
    thrIn[0 +: THR_W]     = THR_W'(t0);
    thrIn[THR_W +: THR_W] = THR_W'(t1);
  endtask

  task automatic fire(int t0, int t1);
    setThr(t0, t1);
    trig = 1'b1;
    @(posedge clk); #1;
    trig = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Count high cycles per channel and channel-1 lead-in over one frame
  task automatic measure(output int h0, output int h1, output int lead1);
    bit seen = 0;
    h0 = 0; h1 = 0; lead1 = 0;
    for (int k = 0; k < FL + 4; k++) begin
      @(negedge clk);
      if (pulseOut[0]) h0++;
      if (pulseOut[1]) begin h1++; seen = 1; end
      else if (busy && !seen) lead1++;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int h0, h1, ld;
    for (int c = 0; c < NCH; c++) begin refThr[c] = MINT; pendThr[c] = MINT; end
    setThr(3000, 2000);
    waitCyc(3);
    curReq = "R1";
    check("R1", int'(busy), 0, "busy in reset");
    check("R1", int'(pulseOut), 0, "pulseOut in reset");
    rstN = 1'b1;
    waitCyc(5);
    check("R1", int'(pulseOut), 0, "pulseOut idle");

    // R2 R3 R9: basic frame, distinct widths
    curReq = "R3";
    fire(3000, 2000);
    measure(h0, h1, ld);
    check("R3", h0, 3000 * DIV, "ch0 high cycles");
    check("R9", h1, 2000 * DIV, "ch1 high cycles");
    check("R2", int'(busy), 0, "busy after one frame");
    curReq = "R8";
    waitCyc(20);
    check("R8", int'(busy), 0, "busy stays idle");

    // R5 R4: clamp both ends, full-throttle lead-in
    curReq = "R5";
    fire(100, 4095);
    measure(h0, h1, ld);
    check("R5", h0, MINT * DIV, "low clamp width");
    check("R5", h1, MAXT * DIV, "high clamp width");
    check("R4", ld, (FRAME - MAXT) * DIV, "minimum lead-in");
    waitCyc(10);

    // R6 R10: mid-frame triggers and untriggered input changes
    curReq = "R10";
    fire(2500, 3500);
    waitCyc(1000);
    setThr(3900, 2100);
    waitCyc(1000);
    curReq = "R6";
    fire(2600, 2400);
    waitCyc(500);
    fire(4000, 2000);
    waitCyc(FL - 2502);
    check("R6", int'(busy), 1, "busy across boundary");
    while (busy) @(posedge clk);
    #1;
    waitCyc(10);

    // R7: trigger in the last cycle of a frame
    curReq = "R7";
    fire(2200, 2800);
    while (refPos != FL - 1) begin @(posedge clk); #1; end
    fire(3300, 2600);
    @(negedge clk);
    check("R7", int'(busy), 1, "busy after edge trigger");
    check("R7", int'(pulseOut), 0, "outputs low at restart");
    @(posedge clk); #1;
    while (busy) @(posedge clk);
    #1;
    curReq = "R8";
    waitCyc(20);
    check("R8", int'(pulseOut), 0, "outputs idle at end");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule